// File: doc/BRIEF.md
# USB Event Status Collector

This block sits between a USB device's serial engine and the CPU interrupt controller. The engine gives it one-cycle strobes for four kinds of event: the host touched one of the endpoint FIFOs, the bus entered suspend, the bus resumed, or a bus reset was detected. Each event leaves a sticky status bit at a fixed position. Firmware can read these bits through a small register port. Any event also produces a single-cycle interrupt pulse, which the interrupt controller latches into its shared USB request flag.

There are two registers. The FIFO request register holds one bit per FIFO. The USB status register holds the suspend, reset and resume bits. Firmware services an event by reading a register and then writing 0 to each bit it has handled. Writing 1 to a bit leaves it as it is. A hardware event that lands in the same cycle as a clear of its bit still takes effect, so no event is lost.

Top module: `usb_evt_collector`

## Requirements
- R1: After reset, both registers read 0 and `usb_irq` is low.
- R2: A strobe on `fifo_acc[i]` sets bit i (i = 0 to 3) of the FIFO request register at address 0. The bit is readable the cycle after the strobe.
- R3: A strobe on `susp_evt` sets bit 0 of the USB status register at address 1.
- R4: A strobe on `resume_evt` sets bit 3 of the USB status register at address 1.
- R5: A strobe on `busrst_evt` sets bit 2 of the USB status register at address 1.
- R6: A set status bit stays set through idle cycles and through writes to other addresses.
- R7: A write clears each bit of the addressed register whose write-data bit is 0. Bits written with 1 keep their value, and a write of 1 never sets a bit.
- R8: When an event strobe and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: `usb_irq` is high for exactly the one cycle after any cycle that has at least one event strobe. Several strobes in the same cycle give a single one-cycle pulse, and strobes on back-to-back cycles give back-to-back pulses.
- R10: Unimplemented bits read 0. These are bits 7:4 at address 0 and bits 1 and 7:4 at address 1. Addresses 2 and 3 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_acc | input | 4 | Per-FIFO host access strobes |
| susp_evt | input | 1 | Bus suspend strobe |
| resume_evt | input | 1 | Bus resume strobe |
| busrst_evt | input | 1 | Bus reset detected strobe |
| reg_addr | input | 2 | Register address (0 = FIFO request, 1 = USB status) |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Write data, where 0 clears a bit and 1 keeps it |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| usb_irq | output | 1 | One-cycle USB interrupt pulse |

## Verification
A wrong status bit shows up on `reg_rdata` as soon as its register is addressed. This can be in the very cycle after the strobe or write that corrupted it, because the read path has no register stage. A fault in the interrupt path shows one cycle after a strobe cycle: `usb_irq` is either missing, stretched over two cycles, or raised without any preceding strobe. The scoreboard reads a register every cycle and tracks `usb_irq` every cycle. A lost set, a clear that reaches the wrong bit, a leak into an unused bit, or a set-versus-clear race resolved the wrong way is therefore reported on the cycle where it first appears.

// File: rtl/usb_evt_pkg.sv
// Package: shared parameters and register layout of the USB event collector.
// Assumes the FIFO count never exceeds the register data width.
package usb_evt_pkg;
    parameter int NUM_FIFO = 4;
    parameter int DATA_W   = 8;
    parameter int ADDR_W   = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_REQ = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STS = ADDR_W'(1);

    // Status register bit positions (firmware decodes these)
    localparam int STS_SUSP = 0;
    localparam int STS_BRST = 2;
    localparam int STS_RES  = 3;

    // Implemented-bit masks
    localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'((1 << NUM_FIFO) - 1);
    localparam logic [DATA_W-1:0] STS_MASK =
        DATA_W'((1 << STS_SUSP) | (1 << STS_BRST) | (1 << STS_RES));

    // Bus event strobes grouped together
    typedef struct packed {
        logic susp;
        logic res;
        logic brst;
    } bus_evt_t;

    localparam int NUM_EVT = NUM_FIFO + $bits(bus_evt_t);
endpackage

// File: rtl/usb_evt_sticky_bank.sv
// Module: a bank of sticky status bits.
// Only bits marked in IMPL_MASK get a flop; the others read constant 0.
// A set input wins over a clearing write to the same bit in the same cycle.
// Assumes set_i strobes are synchronous to clk.
module usb_evt_sticky_bank #(
    parameter int              W         = 8,
    parameter logic [W-1:0]    IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] keep_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic bit_q;
            // Hold the bit; set wins over a clear of the same bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_i[i]) begin
                    bit_q <= 1'b1;
                end else if (wr_en_i && !keep_i[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign bits_q[i] = bit_q;
        end else begin : g_tie
            logic unused_set;
            logic unused_keep;
            // Unimplemented position: inputs ignored, reads zero.
            assign unused_set  = set_i[i];
            assign unused_keep = keep_i[i];
            assign bits_q[i]   = 1'b0;
        end
    end

    assign q_o = bits_q;
endmodule

// File: rtl/usb_evt_regport.sv
// Module: register port address decode and read mux.
// Produces a write strobe for each register and a combinational read value.
// Assumes unmapped addresses should read zero and ignore writes.
module usb_evt_regport
    import usb_evt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic [DW-1:0] req_q_i,
    input  logic [DW-1:0] sts_q_i,
    output logic          req_wr_o,
    output logic          sts_wr_o,
    output logic [DW-1:0] rdata_o
);
    logic req_sel;
    logic sts_sel;

    // Decode which register the address selects.
    always_comb begin
        req_sel = (addr_i == AW'(ADDR_REQ));
        sts_sel = (addr_i == AW'(ADDR_STS));
    end

    // Gate the write strobe per register.
    always_comb begin
        req_wr_o = wr_i && req_sel;
        sts_wr_o = wr_i && sts_sel;
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rdata_o = '0;
        if (req_sel) begin
            rdata_o = req_q_i;
        end else if (sts_sel) begin
            rdata_o = sts_q_i;
        end
    end
endmodule

// File: rtl/usb_evt_irq_pulse.sv
// Module: turns a vector of event strobes into one registered interrupt pulse.
// One pulse per cycle holding at least one strobe, delayed one clock.
// Assumes strobes are single-cycle and synchronous to clk.
module usb_evt_irq_pulse #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    output logic         irq_o
);
    logic any_evt;
    logic irq_q;

    // Merge all event sources.
    always_comb begin
        any_evt = |evt_i;
    end

    // Register the merged event into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_evt;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/usb_evt_collector.sv
// Module: top of the USB event status collector.
// Latches FIFO-access and bus events into two sticky registers, exposes them
// on a simple register port, and raises a one-cycle USB interrupt pulse.
// Assumes all event strobes are one cycle wide and synchronous to clk.
module usb_evt_collector
    import usb_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FIFO-1:0] fifo_acc,
    input  logic                susp_evt,
    input  logic                resume_evt,
    input  logic                busrst_evt,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                usb_irq
);
    bus_evt_t            bus_evt;
    logic [DATA_W-1:0]   req_set;
    logic [DATA_W-1:0]   sts_set;
    logic [DATA_W-1:0]   req_q;
    logic [DATA_W-1:0]   sts_q;
    logic                req_wr;
    logic                sts_wr;
    logic [NUM_EVT-1:0]  all_evt;

    // Group the bus strobes.
    always_comb begin
        bus_evt.susp = susp_evt;
        bus_evt.res  = resume_evt;
        bus_evt.brst = busrst_evt;
    end

    // Place FIFO strobes at their request-register positions.
    always_comb begin
        req_set                 = '0;
        req_set[NUM_FIFO-1:0]   = fifo_acc;
    end

    // Place bus strobes at their status-register positions.
    always_comb begin
        sts_set           = '0;
        sts_set[STS_SUSP] = bus_evt.susp;
        sts_set[STS_BRST] = bus_evt.brst;
        sts_set[STS_RES]  = bus_evt.res;
    end

    // Collect every event source for the interrupt.
    always_comb begin
        all_evt = {fifo_acc, bus_evt};
    end

    usb_evt_regport #(
        .DW (DATA_W),
        .AW (ADDR_W)
    ) u_port (
        .addr_i   (reg_addr),
        .wr_i     (reg_wr),
        .req_q_i  (req_q),
        .sts_q_i  (sts_q),
        .req_wr_o (req_wr),
        .sts_wr_o (sts_wr),
        .rdata_o  (reg_rdata)
    );

    usb_evt_sticky_bank #(
        .W         (DATA_W),
        .IMPL_MASK (REQ_MASK)
    ) u_req_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (req_set),
        .wr_en_i (req_wr),
        .keep_i  (reg_wdata),
        .q_o     (req_q)
    );

    usb_evt_sticky_bank #(
        .W         (DATA_W),
        .IMPL_MASK (STS_MASK)
    ) u_sts_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (sts_set),
        .wr_en_i (sts_wr),
        .keep_i  (reg_wdata),
        .q_o     (sts_q)
    );

    usb_evt_irq_pulse #(
        .N (NUM_EVT)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (all_evt),
        .irq_o (usb_irq)
    );
endmodule

// File: rtl/usb_evt_collector_chk.sv
// Checker: temporal properties of the USB event collector, bound to its top.
module usb_evt_collector_chk
    import usb_evt_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_FIFO-1:0] fifo_acc,
    input logic                susp_evt,
    input logic                resume_evt,
    input logic                busrst_evt,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                usb_irq,
    input logic [DATA_W-1:0]   req_q,
    input logic [DATA_W-1:0]   sts_q
);
    logic any_strobe;
    logic req_write;
    assign any_strobe = (|fifo_acc) || susp_evt || resume_evt || busrst_evt;
    assign req_write  = reg_wr && (reg_addr == ADDR_REQ);

    p_fifo_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_acc != '0) |=> ((req_q[NUM_FIFO-1:0] & $past(fifo_acc)) == $past(fifo_acc)));

    p_susp_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        susp_evt |=> sts_q[STS_SUSP]);

    p_resume_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt |=> sts_q[STS_RES]);

    p_busrst_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busrst_evt |=> sts_q[STS_BRST]);

    p_req_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_write |=> ((req_q & $past(req_q)) == $past(req_q)));

    p_req_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && fifo_acc == '0) |=>
            (req_q[NUM_FIFO-1:0] == ($past(req_q[NUM_FIFO-1:0]) & $past(reg_wdata[NUM_FIFO-1:0]))));

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> usb_irq);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> !usb_irq);

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_REQ && reg_addr != ADDR_STS) |-> (reg_rdata == '0));
endmodule

bind usb_evt_collector usb_evt_collector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_acc   (fifo_acc),
    .susp_evt   (susp_evt),
    .resume_evt (resume_evt),
    .busrst_evt (busrst_evt),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .usb_irq    (usb_irq),
    .req_q      (req_q),
    .sts_q      (sts_q)
);

// File: tb/usb_evt_collector_tb.sv
// Scoreboard bench: the driver applies one cycle of stimulus, updates a model
// and queues the expected read value and interrupt; the monitor compares.
module usb_evt_collector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fifo_acc = '0;
    logic       susp_evt = 1'b0;
    logic       resume_evt = 1'b0;
    logic       busrst_evt = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       usb_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [3:0] m_req = '0;
    logic [7:0] m_sts = '0;

    always #4 clk = ~clk;

    usb_evt_collector u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_acc(fifo_acc), .susp_evt(susp_evt),
        .resume_evt(resume_evt), .busrst_evt(busrst_evt), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .usb_irq(usb_irq)
    );

    // Driver: one clock of stimulus plus its expected outcome.
    task automatic cyc(input logic [3:0] f, input logic s, input logic r,
                       input logic b, input logic wr, input logic [1:0] a,
                       input logic [7:0] d, input string tag);
        exp_t e;
        logic [7:0] sset;
        @(negedge clk);
        fifo_acc = f; susp_evt = s; resume_evt = r; busrst_evt = b;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        sset = 8'h00;
        sset[0] = s; sset[2] = b; sset[3] = r;
        if (wr && a == 2'd0) m_req = (m_req & d[3:0]) | f;
        else                 m_req = m_req | f;
        if (wr && a == 2'd1) m_sts = ((m_sts & d) | sset) & 8'h0D;
        else                 m_sts = (m_sts | sset) & 8'h0D;
        case (a)
            2'd0:    e.rd = {4'h0, m_req};
            2'd1:    e.rd = m_sts;
            default: e.rd = 8'h00;
        endcase
        e.irq = (|f) | s | r | b;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic [1:0] a, input string tag);
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, tag);
    endtask

    // Monitor: compare after each edge, away from it.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks += 2;
                if (reg_rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.tag, reg_rdata, e.rd);
                end
                if (usb_irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s usb_irq actual=%b expected=%b", e.tag, usb_irq, e.irq);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(2'd0, "R1");
        idle(2'd1, "R1");
        // R2 each FIFO bit alone
        for (int i = 0; i < 4; i++) begin
            cyc(4'(1 << i), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R2");
            idle(2'd0, "R2");
        end
        // R6 sticky through idle and other-address writes
        idle(2'd0, "R6");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h00, "R6");
        idle(2'd0, "R6");
        // R7 clear bit 1 only, keep others
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFD, "R7");
        idle(2'd0, "R7");
        // R3, R4, R5 bus events
        cyc(4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00, "R3");
        idle(2'd1, "R3");
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00, "R4");
        idle(2'd1, "R4");
        cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00, "R5");
        idle(2'd1, "R5");
        // R7 clear status bits one by one, ones never set
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFE, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hF3, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFF, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h00, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFF, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, "R7");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFF, "R7");
        // R9 simultaneous events give one pulse
        cyc(4'h5, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
        idle(2'd1, "R9");
        idle(2'd1, "R9");
        // R9 back-to-back strobes give back-to-back pulses
        cyc(4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
        cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00, "R9");
        idle(2'd0, "R9");
        // R8 set wins against a clear of the same bit
        cyc(4'h4, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00, "R8");
        idle(2'd0, "R8");
        cyc(4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h00, "R8");
        idle(2'd1, "R8");
        // R10 unmapped addresses read zero, writes ignored
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, "R10");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 8'h00, "R10");
        idle(2'd0, "R10");
        idle(2'd1, "R10");
        cyc(4'hF, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 8'h00, "R10");
        idle(2'd2, "R10");
        idle(2'd0, "R10");
        idle(2'd1, "R10");
        // R1 reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_req = '0;
        m_sts = '0;
        idle(2'd0, "R1");
        idle(2'd1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule